// File: doc/BRIEF.md
# DTMF Steering and Output Latch Controller

This block sits behind a dual-tone frequency detector. The detector raises a tone-valid flag and presents a 4-bit digit code while it recognises a legal tone pair. The controller decides whether that flag lasted long enough to count as a digit. It does this with a digital guard-time timer instead of an external RC network. An accepted code is loaded into an output register. After a fixed settling delay, a delayed-steering strobe is raised so that downstream logic can read a stable code.

Once a digit is registered, it ends only after the tone-valid flag has stayed low for a separate, independently programmed absence guard time. Shorter dropouts inside a digit are absorbed. Both guard times are programmed in milliseconds. A millisecond tick is derived from the system clock by a parameterized divider. With the defaults of 250,000 cycles per tick and 5,000 settle cycles at 250 MHz, a guard value of 30 accepts 40 ms tones and rejects 20 ms bursts.

The code bus is gated by an output enable. The high-impedance state is modelled as a drive flag plus zeroed data. A guard-time status output follows the tone-valid flag while a digit is held.

Top module: `tone_steer_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the output register to 4'h0 and drives `strobeDelayed` and `guardOut` low.
- R2: A tone-valid burst shorter than `presentGuard` ticks (`presentGuard`*TICK_DIV cycles) leaves the output register, `strobeDelayed` and `guardOut` unchanged.
- R3: When `earlyDet` is sampled high on `presentGuard`*TICK_DIV+2 consecutive rising edges, the code on `detCode` is loaded on the last of those edges.
  - `guardOut` rises on that same edge.
  - The loaded code is visible on the bus 22 cycles after the first sampled edge when `presentGuard`=5 and TICK_DIV=4.
- R4: While a digit is held, `guardOut` follows `earlyDet` with one cycle of delay.
  - It is high only when `earlyDet` was high on the previous edge.
- R5: `strobeDelayed` is low while the output register changes.
  - It rises exactly SETTLE_CYCLES cycles after the load.
- R6: During a held digit, a low period of `earlyDet` shorter than `absentGuard` ticks keeps `strobeDelayed` high and the output register unchanged.
- R7: A low period of `earlyDet` sampled on at least `absentGuard`*TICK_DIV+1 edges ends the digit, and `strobeDelayed` falls.
  - The code stays in the output register.
- R8: With `outEnable` low, `busDrive` is low and `busData` is 4'h0.
  - With `outEnable` high, `busDrive` is high and `busData` shows the last registered code.
- R9: `presentGuard` and `absentGuard` act independently.
  - A short present guard with a long absent guard, and the reverse, each give their own accept and end thresholds.
- R10: A new code replaces the held code only when it is itself registered under R3.
  - An invalid burst with a different code leaves the old code on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| earlyDet | input | 1 | Tone-valid flag from the frequency detector |
| detCode | input | 4 | Decoded digit code from the detector |
| presentGuard | input | GUARD_W | Tone-present guard time in ticks |
| absentGuard | input | GUARD_W | Tone-absent guard time in ticks |
| outEnable | input | 1 | Output enable for the code bus |
| busData | output | 4 | Registered code when enabled, 0 otherwise |
| busDrive | output | 1 | High when the bus is driven (low models high impedance) |
| strobeDelayed | output | 1 | Delayed steering strobe, high while a registered digit is held |
| guardOut | output | 1 | Guard-time status, high while a registered tone is still present |

## Verification
Two events can coincide in one cycle: the settle delay completing, which raises the strobe, and the tone-valid flag dropping, which starts the absence timer. The bench provokes this by watching for the code change and counting SETTLE_CYCLES-1 cycles. It then drops `earlyDet` so that the first low sample lands on the strobe-raising edge. It judges that the strobe still rises on time, that `guardOut` falls one cycle after the drop, and that the digit ends only after the full absence guard.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_QUAL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_HOLD   = 2'd3
  } steerState_t;

  typedef struct packed {
    logic timerClr;
    logic selAbsent;
    logic loadCode;
    logic settleClr;
  } steerCtl_t;

endpackage

// File: rtl/steer_timer.sv
module steer_timer #(
  parameter int TICK_DIV = 250000,
  parameter int GUARD_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [GUARD_W-1:0] target,
  output logic               expired
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]   preCnt;
  logic [GUARD_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
      if (tickCnt != '1) tickCnt <= tickCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign expired = (tickCnt >= target);
endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import tone_steer_pkg::*;
#(
  parameter int TICK_DIV      = 250000,
  parameter int GUARD_W       = 8,
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic               clk,
  input  logic               rst,
  input  steerCtl_t          ctl,
  input  logic [3:0]         detCode,
  input  logic [GUARD_W-1:0] presentGuard,
  input  logic [GUARD_W-1:0] absentGuard,
  input  logic               outEnable,
  output logic               guardExpired,
  output logic               settleDone,
  output logic [3:0]         busData,
  output logic               busDrive
);
  localparam int SET_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);

  logic [3:0]         codeReg;
  logic [SET_W-1:0]   settleCnt;
  logic [GUARD_W-1:0] guardTarget;

  assign guardTarget = ctl.selAbsent ? absentGuard : presentGuard;

  steer_timer #(.TICK_DIV(TICK_DIV), .GUARD_W(GUARD_W)) guardTimer (
    .clk     (clk),
    .rst     (rst),
    .clr     (ctl.timerClr),
    .target  (guardTarget),
    .expired (guardExpired)
  );

  always_ff @(posedge clk) begin
    if (rst) codeReg <= 4'h0;
    else if (ctl.loadCode) codeReg <= detCode;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.settleClr) settleCnt <= '0;
    else if (settleCnt != SET_LAST) settleCnt <= settleCnt + 1'b1;
  end

  assign settleDone = (settleCnt == SET_LAST);
  assign busDrive   = outEnable;
  assign busData    = outEnable ? codeReg : 4'h0;
endmodule

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import tone_steer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      earlyDet,
  input  logic      guardExpired,
  input  logic      settleDone,
  output steerCtl_t ctl,
  output logic      strobeDelayed,
  output logic      guardOut
);
  steerState_t state, nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        ctl.timerClr = 1'b1;
        if (earlyDet) nextState = ST_QUAL;
      end
      ST_QUAL: begin
        if (!earlyDet) begin
          nextState = ST_IDLE;
        end else if (guardExpired) begin
          ctl.loadCode  = 1'b1;
          ctl.settleClr = 1'b1;
          ctl.timerClr  = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      default: begin
        ctl.selAbsent = 1'b1;
        if (earlyDet) ctl.timerClr = 1'b1;
        else if (guardExpired) nextState = ST_IDLE;
        if (state == ST_SETTLE && settleDone && nextState != ST_IDLE)
          nextState = ST_HOLD;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      strobeDelayed <= 1'b0;
      guardOut      <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == ST_IDLE) strobeDelayed <= 1'b0;
      else if (state == ST_SETTLE && nextState == ST_HOLD) strobeDelayed <= 1'b1;
      if (ctl.loadCode) guardOut <= 1'b1;
      else if (nextState == ST_SETTLE || nextState == ST_HOLD) guardOut <= earlyDet;
      else guardOut <= 1'b0;
    end
  end
endmodule

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl
  import tone_steer_pkg::*;
#(
  parameter int TICK_DIV      = 250000,
  parameter int GUARD_W       = 8,
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               earlyDet,
  input  logic [3:0]         detCode,
  input  logic [GUARD_W-1:0] presentGuard,
  input  logic [GUARD_W-1:0] absentGuard,
  input  logic               outEnable,
  output logic [3:0]         busData,
  output logic               busDrive,
  output logic               strobeDelayed,
  output logic               guardOut
);
  steerCtl_t ctl;
  logic      guardExpired;
  logic      settleDone;

  steer_ctrl ctrl (
    .clk           (clk),
    .rst           (rst),
    .earlyDet      (earlyDet),
    .guardExpired  (guardExpired),
    .settleDone    (settleDone),
    .ctl           (ctl),
    .strobeDelayed (strobeDelayed),
    .guardOut      (guardOut)
  );

  steer_datapath #(
    .TICK_DIV(TICK_DIV), .GUARD_W(GUARD_W), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) dp (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .detCode      (detCode),
    .presentGuard (presentGuard),
    .absentGuard  (absentGuard),
    .outEnable    (outEnable),
    .guardExpired (guardExpired),
    .settleDone   (settleDone),
    .busData      (busData),
    .busDrive     (busDrive)
  );
endmodule

// File: rtl/tone_steer_checker.sv
module tone_steer_checker (
  input logic       clk,
  input logic       rst,
  input logic       earlyDet,
  input logic       outEnable,
  input logic [3:0] busData,
  input logic       busDrive,
  input logic       strobeDelayed,
  input logic       guardOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!strobeDelayed && !guardOut));

  // R4
  guard_follows_chk: assert property (@(posedge clk) disable iff (rst)
    guardOut |-> $past(earlyDet));

  // R5
  quiet_update_chk: assert property (@(posedge clk) disable iff (rst)
    (outEnable && $past(outEnable) && busData != $past(busData)) |-> !strobeDelayed);

  // R7
  end_after_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strobeDelayed) |-> !$past(earlyDet));

  // R8
  bus_off_chk: assert property (@(posedge clk) disable iff (rst)
    !outEnable |-> (!busDrive && busData == 4'h0));

  // R5
  strobe_after_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobeDelayed) |-> $past(guardOut) || $past(earlyDet) || !guardOut);
endmodule

bind tone_steer_ctrl tone_steer_checker steerChk (
  .clk           (clk),
  .rst           (rst),
  .earlyDet      (earlyDet),
  .outEnable     (outEnable),
  .busData       (busData),
  .busDrive      (busDrive),
  .strobeDelayed (strobeDelayed),
  .guardOut      (guardOut)
);

// File: tb/tb_tone_steer_ctrl.sv
module tb_tone_steer_ctrl;
  localparam int DIV    = 4;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       earlyDet = 1'b0;
  logic [3:0] detCode = 4'h0;
  logic [7:0] presentGuard = 8'd5;
  logic [7:0] absentGuard = 8'd5;
  logic       outEnable = 1'b1;
  logic [3:0] busData;
  logic       busDrive;
  logic       strobeDelayed;
  logic       guardOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tone_steer_ctrl #(.TICK_DIV(DIV), .GUARD_W(8), .SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst(rst), .earlyDet(earlyDet), .detCode(detCode),
    .presentGuard(presentGuard), .absentGuard(absentGuard),
    .outEnable(outEnable), .busData(busData), .busDrive(busDrive),
    .strobeDelayed(strobeDelayed), .guardOut(guardOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold earlyDet high for n cycles while watching that nothing registers
  task automatic shortBurst(input logic [3:0] code, input int n, input logic [3:0] keep);
    bit bad = 1'b0;
    detCode  = code;
    earlyDet = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busData != keep || guardOut) bad = 1'b1;
    end
    earlyDet = 1'b0;
    idleCycles(4);
    check(!bad && busData == keep && !guardOut, "R2 short burst ignored", busData, keep);
  endtask

  // raise tone and return cycles until the code appears
  task automatic startTone(input logic [3:0] code, output int lat);
    lat = 0;
    detCode  = code;
    earlyDet = 1'b1;
    do begin
      @(negedge clk);
      lat++;
    end while (busData != code && lat < 200);
  endtask

  task automatic endTone(input int lowCycles);
    earlyDet = 1'b0;
    idleCycles(lowCycles);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    idleCycles(3);
    rst = 1'b0;
    @(negedge clk);
    check(busData == 4'h0, "R1 code after reset", busData, 0);
    check(!strobeDelayed && !guardOut, "R1 strobe/guard after reset",
          {strobeDelayed, guardOut}, 0);
  endtask

  task automatic t_accept;
    int lat;
    int sl;
    shortBurst(4'h5, 14, 4'h0);
    startTone(4'h7, lat);
    check(lat == 22, "R3 accept latency", lat, 22);
    check(guardOut == 1'b1, "R3 guardOut on registration", guardOut, 1);
    check(!strobeDelayed, "R5 strobe low at update", strobeDelayed, 0);
    sl = 0;
    do begin
      @(negedge clk);
      sl++;
    end while (!strobeDelayed && sl < 50);
    check(sl == SETTLE, "R5 settle delay", sl, SETTLE);
    idleCycles(5);
    check(guardOut == 1'b1, "R4 guard high with tone", guardOut, 1);
    earlyDet = 1'b0;
    @(negedge clk);
    check(guardOut == 1'b0, "R4 guard follows drop", guardOut, 0);
    idleCycles(29);
    check(!strobeDelayed, "R7 strobe ends after pause", strobeDelayed, 0);
    check(busData == 4'h7, "R7 code retained", busData, 7);
  endtask

  task automatic t_dropout;
    int lat;
    bit bad = 1'b0;
    startTone(4'h9, lat);
    idleCycles(8);
    earlyDet = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!strobeDelayed || busData != 4'h9) bad = 1'b1;
    end
    earlyDet = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!strobeDelayed || busData != 4'h9) bad = 1'b1;
    end
    check(!bad, "R6 dropout tolerated", strobeDelayed, 1);
    endTone(30);
    check(!strobeDelayed, "R7 end after dropout digit", strobeDelayed, 0);
  endtask

  task automatic t_enable;
    outEnable = 1'b0;
    @(negedge clk);
    check(!busDrive && busData == 4'h0, "R8 bus released", {busDrive, busData}, 0);
    outEnable = 1'b1;
    @(negedge clk);
    check(busDrive && busData == 4'h9, "R8 bus shows last code", busData, 9);
  endtask

  task automatic t_replace;
    int lat;
    shortBurst(4'h3, 10, 4'h9);
    check(busData == 4'h9, "R10 invalid burst keeps code", busData, 9);
    startTone(4'hC, lat);
    check(busData == 4'hC, "R10 valid tone replaces", busData, 12);
    endTone(30);
  endtask

  task automatic t_independent;
    int lat;
    bit bad = 1'b0;
    presentGuard = 8'd2;
    absentGuard  = 8'd8;
    startTone(4'h1, lat);
    check(lat == 10, "R9 short present guard latency", lat, 10);
    idleCycles(6);
    earlyDet = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (!strobeDelayed) bad = 1'b1;
    end
    check(!bad, "R9 long absent guard keeps digit", strobeDelayed, 1);
    idleCycles(12);
    check(!strobeDelayed, "R9 digit ends after long guard", strobeDelayed, 0);
    presentGuard = 8'd8;
    absentGuard  = 8'd2;
    shortBurst(4'h2, 20, 4'h1);
    startTone(4'h4, lat);
    check(lat == 34, "R9 long present guard latency", lat, 34);
    idleCycles(6);
    endTone(12);
    check(!strobeDelayed, "R9 short absent guard ends digit", strobeDelayed, 0);
    presentGuard = 8'd5;
    absentGuard  = 8'd5;
  endtask

  task automatic t_collide;
    int lat;
    startTone(4'h6, lat);
    idleCycles(SETTLE - 1);
    earlyDet = 1'b0;
    @(negedge clk);
    check(strobeDelayed == 1'b1, "R5 strobe rises despite drop", strobeDelayed, 1);
    check(guardOut == 1'b0, "R4 guard falls with drop", guardOut, 0);
    idleCycles(10);
    check(strobeDelayed == 1'b1, "R6 held inside absent guard", strobeDelayed, 1);
    idleCycles(20);
    check(!strobeDelayed && busData == 4'h6, "R7 end after collision", busData, 6);
  endtask

  initial begin
    t_reset();
    t_accept();
    t_dropout();
    t_enable();
    t_replace();
    t_independent();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule